// File: doc/BRIEF.md
# Dual-Path Event Detector with Debounce

This block watches two external inputs and turns qualified activity on either of them into a sticky flag and a shared interrupt. It runs directly on a 32.768 kHz clock: every rising clock edge is one tick. The fast path takes a cleanly conditioned digital signal and counts its rising edges. Once the programmed number of events has been seen, it sets its flag. The slow path takes a bouncing mechanical switch and accepts a new level only after the level has held still for a selectable window. An accepted change sets its flag. Software releases each flag on its own with a clear strobe. Both inputs are first retimed by a two-flop synchronizer.

An override bit turns the fast input into a watchdog kick source. While the bit is set, the fast input does no counting. Each rising or falling edge then gives a one-tick `wdt_kick` pulse instead.

The fast path is a three-state machine:
- `HS_OFF` goes to `HS_COUNT` when enabled and not overridden.
- `HS_COUNT` returns to `HS_OFF` on disable or override. It moves to `HS_DONE` when the counted rising edge reaches the target.
- `HS_DONE` returns to `HS_COUNT` or `HS_OFF` on a clear.

The slow path is a four-state machine:
- `LS_OFF` tracks the input as its baseline and goes to `LS_WATCH` when enabled.
- `LS_WATCH` goes to `LS_SETTLE` when the input differs from the baseline.
- `LS_SETTLE` goes back to `LS_WATCH` on a bounce, or to `LS_DONE` when the window has elapsed.
- `LS_DONE` goes to `LS_WATCH` or `LS_OFF` on a clear, and the current level becomes the new baseline.
- Disabling a path sends `LS_WATCH` or `LS_SETTLE` to `LS_OFF`.

Top module: `evt_detect_top`

## Requirements
- R1: Out of reset, `hs_flag`, `ls_flag`, `irq` and `wdt_kick` are all low.
- R2: With `cfg_enable[1]`=1 and `cfg_wdt_override`=0, only rising edges of `hs_in` are counted; falling edges are not. `hs_flag` rises when the count reaches `cfg_target`. It becomes visible after the third rising clock edge, counting the edge that first samples the input change as the first.
- R3: A `cfg_target` of 0 behaves as a target of 1.
- R4: Each flag stays set until its clear strobe (`clr_hs` or `clr_ls`) is sampled high. The flag is then low after that same edge. Clearing `hs_flag` also restarts the event count from zero.
- R5: `ls_flag` sets only after a new `ls_in` level has held for W ticks, where W is 1024 when `cfg_long_db`=0 and 16384 when it is 1. The flag is low after clock edge W+2 and high after edge W+3, counting the first sampling edge as edge 1. A level that returns before the window elapses sets nothing.
- R6: Both a low-to-high and a high-to-low change of `ls_in` are accepted as slow events.
- R7: In `cfg_enable`, bit 1 enables the fast path and bit 0 enables the slow path: 00 means neither, 01 slow only, 10 fast only, 11 both. A disabled path never sets its flag.
- R8: While `cfg_wdt_override`=1, the fast path does not count, whatever `cfg_enable` holds. Every rising and every falling edge of `hs_in` gives a one-cycle `wdt_kick` pulse, which is high after the third clock edge and low after the fourth.
- R9: `irq` is high exactly while at least one flag is set.
- R10: Slow-input changes that occur while `ls_flag` is set are not reported. On a clear, the current level becomes the new baseline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_in | input | 1 | Conditioned fast event input |
| ls_in | input | 1 | Mechanical switch input |
| cfg_enable | input | 2 | Path enables: bit 1 fast, bit 0 slow |
| cfg_wdt_override | input | 1 | Route fast edges to the watchdog kick |
| cfg_long_db | input | 1 | Debounce window select: 0 = 1024 ticks, 1 = 16384 ticks |
| cfg_target | input | CNT_W | Fast event target (0 treated as 1) |
| clr_hs | input | 1 | Clear strobe for the fast flag |
| clr_ls | input | 1 | Clear strobe for the slow flag |
| hs_flag | output | 1 | Fast path flag |
| ls_flag | output | 1 | Slow path flag |
| irq | output | 1 | Active-high interrupt, OR of both flags |
| wdt_kick | output | 1 | One-tick watchdog kick pulse |

## Verification
Each input change is applied half a cycle before a rising edge, and that edge is counted as edge 1. Two synchronizer flops come first: the fast flag and a kick pulse are due after edge 3, and a kick is gone after edge 4. The slow flag is due after edge W+3. Each timed check samples one time unit after the due edge and also checks the edge just before it, so an extra or missing register stage is caught. Flag clears are due after the single edge that samples the strobe, and they are checked there.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        HS_OFF   = 2'd0,
        HS_COUNT = 2'd1,
        HS_DONE  = 2'd2
    } hs_state_t;

    typedef enum logic [1:0] {
        LS_OFF    = 2'd0,
        LS_WATCH  = 2'd1,
        LS_SETTLE = 2'd2,
        LS_DONE   = 2'd3
    } ls_state_t;

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/evt_hs_path.sv
module evt_hs_path
    import evt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             enable,
    input  logic             override,
    input  logic [CNT_W-1:0] target,
    input  logic             clr,
    output logic             flag,
    output logic             kick
);

    localparam int CW = CNT_W + 1;

    hs_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             prev_q;
    logic             kick_q;
    logic             rise, fall;
    logic [CW-1:0]    cnt_inc;
    logic [CW-1:0]    goal;
    logic             active;

    assign rise    = level & ~prev_q;
    assign fall    = ~level & prev_q;
    assign cnt_inc = {1'b0, cnt_q} + CW'(1);
    assign goal    = (target == '0) ? CW'(1) : {1'b0, target};
    assign active  = enable & ~override;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_OFF;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
            kick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= level;
            kick_q  <= override & (rise | fall);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HS_OFF: begin
                cnt_d = '0;
                if (active) state_d = HS_COUNT;
            end
            HS_COUNT: begin
                if (!active) begin
                    state_d = HS_OFF;
                    cnt_d   = '0;
                end else if (clr) begin
                    cnt_d = '0;
                end else if (rise) begin
                    if (cnt_inc >= goal) begin
                        state_d = HS_DONE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            HS_DONE: begin
                cnt_d = '0;
                if (clr) state_d = active ? HS_COUNT : HS_OFF;
            end
            default: begin
                state_d = HS_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        flag = (state_q == HS_DONE);
        kick = kick_q;
    end

    a_r4_hs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r4_hs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr) |=> !flag);
    a_r8_no_count_override: assert property (@(posedge clk) disable iff (!rst_n)
        (override && !flag) |=> !flag);
    a_r7_hs_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !flag) |=> !flag);
    a_r8_kick_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !override) |-> $past(override));

endmodule

// File: rtl/evt_ls_path.sv
module evt_ls_path
    import evt_pkg::*;
#(
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic enable,
    input  logic long_sel,
    input  logic clr,
    output logic flag
);

    localparam int TW = $clog2(LONG_TICKS + 1);

    ls_state_t     state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic          base_q, base_d;
    logic [TW-1:0] window_m1;

    assign window_m1 = long_sel ? TW'(LONG_TICKS - 1) : TW'(SHORT_TICKS - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_OFF;
            timer_q <= '0;
            base_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            base_q  <= base_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        base_d  = base_q;
        unique case (state_q)
            LS_OFF: begin
                base_d  = level;
                timer_d = '0;
                if (enable) state_d = LS_WATCH;
            end
            LS_WATCH: begin
                timer_d = '0;
                if (!enable) begin
                    state_d = LS_OFF;
                end else if (level != base_q) begin
                    state_d = LS_SETTLE;
                end
            end
            LS_SETTLE: begin
                if (!enable) begin
                    state_d = LS_OFF;
                    timer_d = '0;
                end else if (level == base_q) begin
                    state_d = LS_WATCH;
                    timer_d = '0;
                end else if (timer_q >= window_m1) begin
                    state_d = LS_DONE;
                    base_d  = level;
                    timer_d = '0;
                end else begin
                    timer_d = timer_q + TW'(1);
                end
            end
            LS_DONE: begin
                timer_d = '0;
                if (clr) begin
                    base_d  = level;
                    state_d = enable ? LS_WATCH : LS_OFF;
                end
            end
            default: begin
                state_d = LS_OFF;
                timer_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        flag = (state_q == LS_DONE);
    end

    a_r4_ls_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r4_ls_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr) |=> !flag);
    a_r7_ls_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !flag) |=> !flag);
    a_r10_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> $stable(base_q));
    a_r5_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SETTLE) |-> (timer_q <= TW'(LONG_TICKS - 1)));

endmodule

// File: rtl/evt_detect_top.sv
module evt_detect_top #(
    parameter int CNT_W       = 8,
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_in,
    input  logic             ls_in,
    input  logic [1:0]       cfg_enable,
    input  logic             cfg_wdt_override,
    input  logic             cfg_long_db,
    input  logic [CNT_W-1:0] cfg_target,
    input  logic             clr_hs,
    input  logic             clr_ls,
    output logic             hs_flag,
    output logic             ls_flag,
    output logic             irq,
    output logic             wdt_kick
);

    localparam int SYNC_STAGES = 2;
    localparam int EN_HS       = 1;
    localparam int EN_LS       = 0;

    logic [1:0] synced;

    evt_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({hs_in, ls_in}),
        .dout (synced)
    );

    evt_hs_path #(
        .CNT_W(CNT_W)
    ) hs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (synced[1]),
        .enable  (cfg_enable[EN_HS]),
        .override(cfg_wdt_override),
        .target  (cfg_target),
        .clr     (clr_hs),
        .flag    (hs_flag),
        .kick    (wdt_kick)
    );

    evt_ls_path #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) ls_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (synced[0]),
        .enable  (cfg_enable[EN_LS]),
        .long_sel(cfg_long_db),
        .clr     (clr_ls),
        .flag    (ls_flag)
    );

    assign irq = hs_flag | ls_flag;

endmodule

// File: tb/evt_detect_top_tb_top.sv
module evt_detect_top_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int CNT_W       = 8;
    localparam int SHORT_TICKS = 1024;
    localparam int LONG_TICKS  = 16384;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hs_in = 1'b0;
    logic             ls_in = 1'b0;
    logic [1:0]       cfg_enable = 2'b00;
    logic             cfg_wdt_override = 1'b0;
    logic             cfg_long_db = 1'b0;
    logic [CNT_W-1:0] cfg_target = '0;
    logic             clr_hs = 1'b0;
    logic             clr_ls = 1'b0;
    logic             hs_flag, ls_flag, irq, wdt_kick;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_detect_top #(
        .CNT_W(CNT_W), .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .ls_in(ls_in),
        .cfg_enable(cfg_enable), .cfg_wdt_override(cfg_wdt_override),
        .cfg_long_db(cfg_long_db), .cfg_target(cfg_target),
        .clr_hs(clr_hs), .clr_ls(clr_ls),
        .hs_flag(hs_flag), .ls_flag(ls_flag), .irq(irq), .wdt_kick(wdt_kick)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b @%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wait_edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_hs(logic v);
        @(negedge clk);
        hs_in = v;
    endtask

    task automatic set_ls(logic v);
        @(negedge clk);
        ls_in = v;
    endtask

    task automatic hs_pulse();
        set_hs(1'b1); wait_edges(3);
        set_hs(1'b0); wait_edges(3);
    endtask

    task automatic clear_hs();
        @(negedge clk); clr_hs = 1'b1;
        wait_edges(1);
        @(negedge clk); clr_hs = 1'b0;
    endtask

    task automatic clear_ls();
        @(negedge clk); clr_ls = 1'b1;
        wait_edges(1);
        @(negedge clk); clr_ls = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "hs_flag", hs_flag, 1'b0);
        chk("R1", "ls_flag", ls_flag, 1'b0);
        chk("R1", "irq", irq, 1'b0);
        chk("R1", "wdt_kick", wdt_kick, 1'b0);
    endtask

    task automatic t_hs_count();
        @(negedge clk); cfg_enable = 2'b10; cfg_target = 8'd3;
        wait_edges(4);
        hs_pulse(); hs_pulse();
        chk("R2", "flag after 2 of 3", hs_flag, 1'b0);
        set_hs(1'b1);
        wait_edges(2); chk("R2", "flag edge 2", hs_flag, 1'b0);
        wait_edges(1); chk("R2", "flag edge 3", hs_flag, 1'b1);
        chk("R9", "irq with hs flag", irq, 1'b1);
        set_hs(1'b0); wait_edges(3);
        @(negedge clk); clr_hs = 1'b1;
        wait_edges(1);
        chk("R4", "hs flag cleared", hs_flag, 1'b0);
        chk("R9", "irq released", irq, 1'b0);
        @(negedge clk); clr_hs = 1'b0;
        hs_pulse(); hs_pulse();
        chk("R4", "count restarted", hs_flag, 1'b0);
        hs_pulse();
        chk("R4", "flag after fresh 3", hs_flag, 1'b1);
        clear_hs();
    endtask

    task automatic t_hs_fall();
        @(negedge clk); cfg_enable = 2'b00; cfg_target = 8'd1;
        set_hs(1'b1); wait_edges(4);
        @(negedge clk); cfg_enable = 2'b10;
        wait_edges(4);
        chk("R2", "no flag from enable", hs_flag, 1'b0);
        set_hs(1'b0); wait_edges(5);
        chk("R2", "falling edge ignored", hs_flag, 1'b0);
        set_hs(1'b1); wait_edges(3);
        chk("R2", "rising edge counted", hs_flag, 1'b1);
        set_hs(1'b0);
        clear_hs();
    endtask

    task automatic t_target0();
        @(negedge clk); cfg_target = 8'd0;
        wait_edges(2);
        set_hs(1'b1); wait_edges(3);
        chk("R3", "target 0 acts as 1", hs_flag, 1'b1);
        set_hs(1'b0);
        clear_hs();
    endtask

    task automatic t_disable();
        @(negedge clk); cfg_enable = 2'b01; cfg_target = 8'd1;
        wait_edges(3);
        hs_pulse(); wait_edges(2);
        chk("R7", "hs disabled by 01", hs_flag, 1'b0);
        @(negedge clk); cfg_enable = 2'b00;
        wait_edges(2);
        set_ls(1'b1); wait_edges(SHORT_TICKS + 50);
        chk("R7", "ls disabled by 00", ls_flag, 1'b0);
        set_ls(1'b0); wait_edges(5);
    endtask

    task automatic t_override();
        @(negedge clk); cfg_wdt_override = 1'b1; cfg_enable = 2'b10; cfg_target = 8'd1;
        wait_edges(3);
        set_hs(1'b1);
        wait_edges(2); chk("R8", "kick not yet", wdt_kick, 1'b0);
        wait_edges(1); chk("R8", "kick on rise", wdt_kick, 1'b1);
        wait_edges(1); chk("R8", "kick one cycle", wdt_kick, 1'b0);
        chk("R8", "no counting in override", hs_flag, 1'b0);
        set_hs(1'b0);
        wait_edges(3); chk("R8", "kick on fall", wdt_kick, 1'b1);
        wait_edges(2);
        @(negedge clk); cfg_enable = 2'b00;
        set_hs(1'b1);
        wait_edges(3); chk("R8", "kick with paths off", wdt_kick, 1'b1);
        set_hs(1'b0); wait_edges(5);
        chk("R8", "flag still low", hs_flag, 1'b0);
        @(negedge clk); cfg_wdt_override = 1'b0;
        wait_edges(2);
    endtask

    task automatic t_ls_short();
        @(negedge clk); cfg_enable = 2'b01; cfg_long_db = 1'b0;
        wait_edges(3);
        set_ls(1'b1); wait_edges(SHORT_TICKS / 2);
        set_ls(1'b0); wait_edges(2 * SHORT_TICKS);
        chk("R5", "short pulse rejected", ls_flag, 1'b0);
    endtask

    task automatic t_ls_exact();
        set_ls(1'b1);
        wait_edges(SHORT_TICKS + 2); chk("R5", "ls edge W+2", ls_flag, 1'b0);
        wait_edges(1);               chk("R5", "ls edge W+3", ls_flag, 1'b1);
        chk("R9", "irq with ls flag", irq, 1'b1);
        clear_ls();
        chk("R4", "ls flag cleared", ls_flag, 1'b0);
        set_ls(1'b0);
        wait_edges(SHORT_TICKS + 2); chk("R6", "fall edge W+2", ls_flag, 1'b0);
        wait_edges(1);               chk("R6", "fall accepted", ls_flag, 1'b1);
        set_ls(1'b1); wait_edges(SHORT_TICKS + 400);
        chk("R4", "ls flag held", ls_flag, 1'b1);
        clear_ls();
        wait_edges(2 * SHORT_TICKS);
        chk("R10", "change while set ignored", ls_flag, 1'b0);
    endtask

    task automatic t_ls_long();
        @(negedge clk); cfg_enable = 2'b11; cfg_long_db = 1'b1; cfg_target = 8'd1;
        wait_edges(3);
        hs_pulse();
        chk("R7", "hs on with 11", hs_flag, 1'b1);
        set_ls(1'b0);
        wait_edges(LONG_TICKS + 2); chk("R5", "long edge W+2", ls_flag, 1'b0);
        wait_edges(1);              chk("R5", "long edge W+3", ls_flag, 1'b1);
        clear_hs();
        chk("R9", "irq held by ls", irq, 1'b1);
        clear_ls();
        chk("R9", "irq low with no flag", irq, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_edges(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        wait_edges(2);
        t_reset();
        t_hs_count();
        t_hs_fall();
        t_target0();
        t_disable();
        t_override();
        t_ls_short();
        t_ls_exact();
        t_ls_long();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule